// File: doc/BRIEF.md
# SDRAM Command Timing Monitor

This block watches the command pins that a memory controller drives towards a four-bank SDRAM, one command per clock edge. It turns the pin levels into a command, keeps an open or closed flag and a set of countdown timers for every bank plus a few shared timers, and raises an error pulse carrying a 4-bit rule code whenever a command breaks bank-state legality or a minimum spacing. All spacings are counted in clock cycles and set by parameters.

The monitor is passive: it never drives the bus and never blocks a command. Its state keeps following the bus after a violation, so later checks stay meaningful. It is meant to sit beside a controller in simulation, and it is written so that it can also be synthesized into an on-chip checker.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A command is live only when `cke` is high and `cs_n` is low. Its kind is set by `{ras_n,cas_n,we_n}`: 000 mode set, 001 refresh, 010 precharge (all banks when `a10`=1, else bank `ba`), 011 activate, 100 write, 101 read, 110 burst stop, 111 NOP. When `cs_n` is high or `cke` is low the edge is a NOP and changes no bank state.
- R2: A violation by the command at edge N gives `err`=1 with its code on `err_code` for the cycle after edge N. With no violation, `err`=0 and `err_code`=0. After reset no bank is open and no timer runs. When several rules break at once, the lowest code is reported.
- R3: Any live non-NOP command fewer than T_MRD (2) cycles after a mode set gives code 1.
- R4: Any live non-NOP command fewer than T_RFC (9) cycles after a refresh gives code 2.
- R5: A mode set or refresh while any bank is open gives code 3.
- R6: An activate to an open bank gives code 4. A read or write to a closed bank, or to a bank whose auto-precharge is pending, gives code 5.
- R7: A read or write fewer than T_RCD (3) cycles after the activate of its bank gives code 6.
- R8: A precharge that closes an open bank fewer than T_RAS (6) cycles after that bank's activate gives code 7. This holds for single-bank and all-bank precharge.
- R9: An activate fewer than T_RP (3) cycles after the precharge of its bank gives code 8.
- R10: An activate fewer than T_RC cycles (9 by default) after the previous activate of the same bank gives code 9.
- R11: An activate to a different bank fewer than T_RRD (2) cycles after an activate gives code 10.
- R12: A read or write fewer than T_CCD cycles (1 by default) after the previous read or write gives code 11.
- R13: A read or write with `a10`=1 to an open bank marks it pending. The bank stays open up to and including the cycle BURST_LEN (4) cycles after that command. It is closed after that cycle, and the T_RP spacing counts from that cycle.
- R14: A precharge with `a10`=1 closes every bank. Afterwards a read or write to any bank gives code 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin of the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10: all-bank / auto-precharge flag |
| err | output | 1 | One-cycle violation pulse |
| err_code | output | 4 | Rule code of the violation, 0 when none |

## Verification
A wrong bank flag shows at the ports on the very next command to that bank: either a false code 4 or 5, or a missing one. A wrong timer load or decrement shifts the edge where a code 6 to 11 stops being reported, so sweeping the spacing one cycle at a time across each limit exposes an off-by-one within the cycle after the offending command. Auto-precharge and all-bank precharge errors appear as a wrong close point, which the next activate or column command reveals.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int BA_W      = 2,
  parameter int CW        = 8,
  parameter int T_MRD     = 2,
  parameter int T_RFC     = 9,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RC      = 9,
  parameter int T_RRD     = 2,
  parameter int T_CCD     = 1,
  parameter int BURST_LEN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output logic            err,
  output logic [3:0]      err_code
);
  localparam int NB = 1 << BA_W;

  function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  wire       live   = cke & ~cs_n;
  wire [2:0] op     = {ras_n, cas_n, we_n};
  wire       is_cmd = live && (op != 3'b111);
  wire       is_mrs = live && (op == 3'b000);
  wire       is_ref = live && (op == 3'b001);
  wire       is_pre = live && (op == 3'b010);
  wire       is_act = live && (op == 3'b011);
  wire       is_col = live && (op == 3'b100 || op == 3'b101);

  wire [NB-1:0] sel     = NB'(1) << ba;
  wire [NB-1:0] pre_hit = is_pre ? (a10 ? {NB{1'b1}} : sel) : '0;

  logic [NB-1:0] open_q, pend_q, rcd_nz, ras_nz, rc_nz, rp_nz;

  logic [CW-1:0]   mrd_c, rfc_c, rrd_c, ccd_c;
  logic [BA_W-1:0] last_ba;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mrd_c   <= '0;
      rfc_c   <= '0;
      rrd_c   <= '0;
      ccd_c   <= '0;
      last_ba <= '0;
    end else begin
      mrd_c <= is_mrs ? CW'(T_MRD - 1) : dn(mrd_c);
      rfc_c <= is_ref ? CW'(T_RFC - 1) : dn(rfc_c);
      rrd_c <= is_act ? CW'(T_RRD - 1) : dn(rrd_c);
      ccd_c <= is_col ? CW'(T_CCD - 1) : dn(ccd_c);
      if (is_act) last_ba <= ba;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic          open_r, pend_r;
    logic [CW-1:0] rcd_c, ras_c, rc_c, rp_c, ap_c;
    wire act_b  = is_act && (ba == BA_W'(b));
    wire col_b  = is_col && (ba == BA_W'(b));
    wire apdone = pend_r && (ap_c == '0);
    wire close  = (pre_hit[b] && open_r) || apdone;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_r <= 1'b0;
        pend_r <= 1'b0;
        rcd_c  <= '0;
        ras_c  <= '0;
        rc_c   <= '0;
        rp_c   <= '0;
        ap_c   <= '0;
      end else begin
        if (act_b)      open_r <= 1'b1;
        else if (close) open_r <= 1'b0;
        if (close)                             pend_r <= 1'b0;
        else if (col_b && a10 && open_r)       pend_r <= 1'b1;
        rcd_c <= act_b ? CW'(T_RCD - 1) : dn(rcd_c);
        ras_c <= act_b ? CW'(T_RAS - 1) : dn(ras_c);
        rc_c  <= act_b ? CW'(T_RC - 1)  : dn(rc_c);
        rp_c  <= close ? CW'(T_RP - 1)  : dn(rp_c);
        ap_c  <= (col_b && a10 && !pend_r) ? CW'(BURST_LEN - 1) : dn(ap_c);
      end
    end

    assign open_q[b] = open_r;
    assign pend_q[b] = pend_r;
    assign rcd_nz[b] = rcd_c != '0;
    assign ras_nz[b] = ras_c != '0;
    assign rc_nz[b]  = rc_c != '0;
    assign rp_nz[b]  = rp_c != '0;
  end

  wire v_mrd  = is_cmd && (mrd_c != '0);
  wire v_rfc  = is_cmd && (rfc_c != '0);
  wire v_busy = (is_mrs || is_ref) && (|open_q);
  wire v_aopn = is_act && open_q[ba];
  wire v_ccls = is_col && (!open_q[ba] || pend_q[ba]);
  wire v_rcd  = is_col && open_q[ba] && rcd_nz[ba];
  wire v_ras  = |(pre_hit & open_q & ras_nz);
  wire v_rp   = is_act && rp_nz[ba];
  wire v_rc   = is_act && rc_nz[ba];
  wire v_rrd  = is_act && (rrd_c != '0) && (ba != last_ba);
  wire v_ccd  = is_col && (ccd_c != '0);

  logic [3:0] code;
  always_comb begin
    code = 4'd0;
    if      (v_mrd)  code = 4'd1;
    else if (v_rfc)  code = 4'd2;
    else if (v_busy) code = 4'd3;
    else if (v_aopn) code = 4'd4;
    else if (v_ccls) code = 4'd5;
    else if (v_rcd)  code = 4'd6;
    else if (v_ras)  code = 4'd7;
    else if (v_rp)   code = 4'd8;
    else if (v_rc)   code = 4'd9;
    else if (v_rrd)  code = 4'd10;
    else if (v_ccd)  code = 4'd11;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err      <= 1'b0;
      err_code <= 4'd0;
    end else begin
      err      <= code != 4'd0;
      err_code <= code;
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int BA_W  = 2,
  parameter int T_MRD = 2,
  parameter int T_RFC = 9,
  parameter int T_RCD = 3,
  parameter int T_RRD = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cke,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic [BA_W-1:0] ba,
  input logic            err,
  input logic [3:0]      err_code
);
  wire       live    = cke & ~cs_n;
  wire [2:0] op      = {ras_n, cas_n, we_n};
  wire       cmd_now = live && op != 3'b111;
  wire       act_now = live && op == 3'b011;
  wire       col_now = live && (op == 3'b100 || op == 3'b101);

  logic            p_mrs, p_ref, p_act;
  logic [BA_W-1:0] p_ba;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_mrs <= 1'b0;
      p_ref <= 1'b0;
      p_act <= 1'b0;
      p_ba  <= '0;
    end else begin
      p_mrs <= live && op == 3'b000;
      p_ref <= live && op == 3'b001;
      p_act <= act_now;
      p_ba  <= ba;
    end
  end

  assert_code_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err == (err_code != 4'd0));
  assert_err_after_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(cmd_now));
  assert_mrd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (T_MRD >= 2 && p_mrs && cmd_now) |=> (err && err_code == 4'd1));
  assert_rfc_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RFC >= 2 && p_ref && cmd_now) |=> err);
  assert_rcd_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RCD >= 2 && p_act && col_now && ba == p_ba) |=> err);
  assert_rrd_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RRD >= 2 && p_act && act_now && ba != p_ba) |=> err);
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
  .BA_W(BA_W), .T_MRD(T_MRD), .T_RFC(T_RFC), .T_RCD(T_RCD), .T_RRD(T_RRD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
  .cas_n(cas_n), .we_n(we_n), .ba(ba), .err(err), .err_code(err_code)
);

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;
  localparam logic [2:0] MRS = 3'b000, REF = 3'b001, PRE = 3'b010, ACT = 3'b011;
  localparam logic [2:0] WR = 3'b100, RD = 3'b101, NOP = 3'b111;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = '0;
  logic err;
  logic [3:0] err_code;
  int errs = 0, checks = 0, cyc = 0;
  bit done = 1'b0;

  sdram_cmd_monitor #(.T_RC(12), .T_CCD(2)) i_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .a10(a10), .err(err), .err_code(err_code));

  task automatic step(input logic [2:0] o, input logic [1:0] b, input logic ap,
                      input logic sel, input int exp, input string tag);
    @(negedge clk);
    cs_n = ~sel; {ras_n, cas_n, we_n} = o; ba = b; a10 = ap;
    @(posedge clk); #2;
    checks++;
    if (err !== (exp != 0) || err_code !== 4'(exp)) begin
      errs++;
      $display("FAIL %s: err=%0b code=%0d expected code=%0d", tag, err, err_code, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] o, input logic [1:0] b, input logic ap,
                     input int exp, input string tag);
    step(o, b, ap, 1'b1, exp, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(NOP, 2'd0, 1'b0, 1'b1, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; cke = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      errs++; checks++;
      $display("FAIL watchdog: run hung, cycles=%0d expected below 50000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    idle(2, "R2 reset state quiet");

    for (int g = 1; g <= 3; g++) begin
      do_reset(); cmd(MRS, 0, 0, 0, "R3 mode set");
      idle(g - 1, "R3 gap"); cmd(ACT, 0, 0, g < 2 ? 1 : 0, "R3 command after mode set");
    end
    for (int g = 1; g <= 10; g++) begin
      do_reset(); cmd(REF, 0, 0, 0, "R4 refresh");
      idle(g - 1, "R4 gap"); cmd(ACT, 1, 0, g < 9 ? 2 : 0, "R4 command after refresh");
    end
    do_reset(); cmd(ACT, 0, 0, 0, "R5 act"); idle(3, "R5 gap"); cmd(REF, 0, 0, 3, "R5 refresh with open bank");
    do_reset(); cmd(ACT, 2, 0, 0, "R5 act"); idle(3, "R5 gap"); cmd(MRS, 0, 0, 3, "R5 mode set with open bank");
    do_reset(); cmd(ACT, 0, 0, 0, "R6 act"); idle(11, "R6 gap"); cmd(ACT, 0, 0, 4, "R6 act to open bank");
    do_reset(); cmd(RD, 2, 0, 5, "R6 read to closed bank");
    do_reset(); step(ACT, 1, 0, 1'b0, 0, "R1 deselected act"); idle(3, "R1 gap");
    cmd(WR, 1, 0, 5, "R1 deselected act left bank closed");
    do_reset(); cke = 1'b0; cmd(ACT, 3, 0, 0, "R1 act with cke low"); cke = 1'b1;
    idle(3, "R1 gap"); cmd(RD, 3, 0, 5, "R1 cke-low act left bank closed");

    for (int g = 1; g <= 5; g++) begin
      do_reset(); cmd(ACT, 0, 0, 0, "R7 act");
      idle(g - 1, "R7 gap"); cmd(RD, 0, 0, g < 3 ? 6 : 0, "R7 column after act");
    end
    for (int g = 1; g <= 8; g++) begin
      do_reset(); cmd(ACT, 1, 0, 0, "R8 act");
      idle(g - 1, "R8 gap"); cmd(PRE, 1, 0, g < 6 ? 7 : 0, "R8 precharge after act");
    end
    for (int g = 1; g <= 4; g++) begin
      do_reset(); cmd(ACT, 0, 0, 0, "R9 act"); idle(8, "R9 gap");
      cmd(PRE, 0, 0, 0, "R9 precharge"); idle(g - 1, "R9 gap");
      cmd(ACT, 0, 0, g < 3 ? 8 : 0, "R9 act after precharge");
    end
    for (int g = 9; g <= 13; g++) begin
      do_reset(); cmd(ACT, 2, 0, 0, "R10 act"); idle(5, "R10 gap");
      cmd(PRE, 2, 0, 0, "R10 precharge"); idle(g - 7, "R10 gap");
      cmd(ACT, 2, 0, g < 12 ? 9 : 0, "R10 act after act same bank");
    end
    for (int g = 1; g <= 3; g++) begin
      do_reset(); cmd(ACT, 0, 0, 0, "R11 act");
      idle(g - 1, "R11 gap"); cmd(ACT, 1, 0, g < 2 ? 10 : 0, "R11 act other bank");
    end
    for (int g = 1; g <= 3; g++) begin
      do_reset(); cmd(ACT, 3, 0, 0, "R12 act"); idle(2, "R12 gap");
      cmd(RD, 3, 0, 0, "R12 first column"); idle(g - 1, "R12 gap");
      cmd(WR, 3, 0, g < 2 ? 11 : 0, "R12 second column");
    end
    for (int g = 0; g <= 3; g++) begin
      do_reset(); cmd(ACT, 0, 0, 0, "R13 act"); idle(5, "R13 gap");
      cmd(RD, 0, 1, 0, "R13 read auto-precharge"); idle(g + 3, "R13 burst");
      cmd(ACT, 0, 0, g == 0 ? 4 : (g < 3 ? 8 : 0), "R13 act after auto-precharge close");
    end
    do_reset(); cmd(ACT, 1, 0, 0, "R13 act"); idle(5, "R13 gap");
    cmd(WR, 1, 1, 0, "R13 write auto-precharge"); idle(1, "R13 gap");
    cmd(RD, 1, 0, 5, "R13 column to pending bank");

    do_reset(); cmd(ACT, 0, 0, 0, "R14 act"); idle(1, "R14 gap"); cmd(ACT, 1, 0, 0, "R14 act");
    idle(6, "R14 gap"); cmd(PRE, 0, 1, 0, "R14 precharge all");
    idle(1, "R14 gap"); cmd(ACT, 1, 0, 8, "R14 act too soon after precharge all");
    do_reset(); cmd(ACT, 0, 0, 0, "R14 act"); idle(1, "R14 gap"); cmd(ACT, 1, 0, 0, "R14 act");
    idle(6, "R14 gap"); cmd(PRE, 2, 1, 0, "R14 precharge all");
    idle(2, "R14 gap"); cmd(ACT, 0, 0, 0, "R14 act after precharge all");
    cmd(RD, 1, 0, 5, "R14 bank closed by precharge all");
    do_reset(); cmd(ACT, 0, 0, 0, "R8 act"); idle(1, "R8 gap"); cmd(ACT, 1, 0, 0, "R8 act");
    idle(3, "R8 gap"); cmd(PRE, 0, 1, 7, "R8 precharge all with young bank");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule